// File: doc/BRIEF.md
# Burst Read DMA Engine

This block is a read-only DMA master. Software or a sequencer gives it a start command: a byte address and a byte count. The block then fetches that region over an AXI4 read address and read data channel pair and streams every returned data beat into the write port of a local scratchpad. The first beat goes to scratchpad index zero and later beats follow in order. When the last beat of the last burst has been accepted, the block raises a one-cycle done pulse. With the pulse it reports a sticky error flag, which is set if any beat came back with a response other than OKAY.

The engine works out each burst itself. A burst is as long as the smallest of three limits: the beats left in the transfer, the 256-beat AXI4 ceiling, and the beats left before the next 4 KB address boundary. A transfer that would run across a 4 KB page is therefore cut into several incrementing bursts. Only one burst is in flight at a time. The next burst address is the previous burst address plus the bytes that burst moved.

Bus width, address width, byte-count width, scratchpad index width, burst ceiling and boundary size are all parameters. Two further parameters pick variants: whether the boundary split is built, and whether the scratchpad write port is registered or passed through combinationally.

Top module: `rd_burst_dma`

## Requirements
- R1: A start command is taken only when `busy_o` is low. `busy_o` is high from the cycle after the command is taken up to and including the done cycle. A `start_i` pulse while busy changes neither the bursts issued nor the data written.
- R2: Each burst drives `arburst_o` = 2'b01 (incrementing), `arsize_o` = log2 of the bus width in bytes (3 for a 64-bit bus), and `arlen_o` = burst beats minus one, where one beat is one bus word.
- R3: With the boundary split enabled, no burst spans a 4 KB boundary. The byte offset of `araddr_o` within its 4 KB page, plus (`arlen_o`+1) times the bus bytes, never exceeds 4096.
- R4: A burst carries at most 256 beats. Each burst is as long as the smallest of the remaining beats, 256, and the beats left to the page end. The next burst starts at the previous burst address plus that burst's byte count.
- R5: Once `arvalid_o` is raised, it stays high with `araddr_o` and `arlen_o` unchanged until a cycle in which `arready_i` is high.
- R6: Between the address handshake of a burst and the acceptance of its RLAST beat, `rready_o` is high and no new address is presented. While idle, both `arvalid_o` and `rready_o` are low.
- R7: The k-th beat accepted in a transfer (counting from 0) is written with its data unchanged to scratchpad index k. In the default registered variant, `sp_we_o` is high in the cycle after the beat is accepted.
- R8: `done_o` is a single-cycle pulse. It is high in the cycle right after the RLAST beat of the final burst is accepted, and never earlier.
- R9: Any accepted beat with `rresp_i` not equal to 2'b00 sets `err_o`. `err_o` stays set through the done pulse and is cleared when the next start command is taken.
- R10: A start command with a byte count of zero issues no burst and gives the done pulse in the cycle right after the command is taken.
- R11: After reset, `busy_o`, `done_o`, `err_o`, `arvalid_o`, `rready_o` and `sp_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start command strobe |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| start_bytes_i | input | CNT_W | Number of bytes to fetch |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky non-OKAY response flag |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| araddr_o | output | ADDR_W | Burst start address |
| arlen_o | output | 8 | Burst beats minus one |
| arsize_o | output | 3 | log2 of bytes per beat |
| arburst_o | output | 2 | Burst type, always incrementing |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |
| rdata_i | input | DATA_W | Read data beat |
| rresp_i | input | 2 | Read response of the beat |
| rlast_i | input | 1 | Last beat of the burst |
| sp_we_o | output | 1 | Scratchpad write enable |
| sp_addr_o | output | SP_AW | Scratchpad word index |
| sp_wdata_o | output | DATA_W | Scratchpad write data |

## Verification
The properties take several things as given:
- the start address is aligned to the bus width and the byte count is a whole number of bus words;
- the memory side returns exactly `arlen_o`+1 beats per burst, with RLAST on the final beat only;
- read data is never offered while no burst is outstanding;
- a transfer never holds more words than the scratchpad index can count.

The stimulus keeps to these limits. It masks the low address bits and draws byte counts as multiples of eight up to 700 words. Its memory responder loads its beat count from the accepted ARLEN and marks RLAST from that count. It drives `rvalid_i` only while that count is non-zero.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT_AR,
      ST_DATA,
      ST_FIN
   } dma_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam int         AXLEN_W    = 8;

endpackage

// File: rtl/dma_burst_plan.sv
module dma_burst_plan #(
   parameter int CNT_W          = 16,
   parameter int BUS_BYTES      = 8,
   parameter int MAX_BEATS      = 256,
   parameter int BOUND_BYTES    = 4096,
   parameter bit SPLIT_AT_BOUND = 1'b1,
   parameter int LEN_W          = $clog2(MAX_BEATS) + 1,
   parameter int BND_LG         = $clog2(BOUND_BYTES)
) (
   input  logic [BND_LG-1:0] page_off_i,
   input  logic [CNT_W-1:0]  rem_beats_i,
   output logic [LEN_W-1:0]  beats_o,
   output logic [7:0]        arlen_o
);
   localparam int BB_LG  = $clog2(BUS_BYTES);
   localparam int ROOM_W = BND_LG + 1;
   localparam int CMP_W  = (CNT_W > ROOM_W) ? CNT_W : ROOM_W;

   logic [ROOM_W-1:0] room_beats;

   generate
      if (SPLIT_AT_BOUND) begin : g_split
         logic [ROOM_W-1:0] room_bytes;
         always_comb begin
            room_bytes = ROOM_W'(BOUND_BYTES) - ROOM_W'(page_off_i);
            room_beats = room_bytes >> BB_LG;
         end
      end else begin : g_nosplit
         logic unused_off;
         assign unused_off = ^page_off_i;
         assign room_beats = ROOM_W'(MAX_BEATS);
      end
   endgenerate

   logic [CMP_W-1:0] pick;

   always_comb begin
      pick = (CMP_W'(rem_beats_i) < CMP_W'(MAX_BEATS)) ? CMP_W'(rem_beats_i)
                                                      : CMP_W'(MAX_BEATS);
      if (CMP_W'(room_beats) < pick) begin
         pick = CMP_W'(room_beats);
      end
      beats_o = LEN_W'(pick);
      arlen_o = 8'(pick - CMP_W'(1));
   end

endmodule

// File: rtl/dma_ar_chan.sv
module dma_ar_chan #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        len_i,
   input  logic              arready_i,
   output logic              arvalid_o,
   output logic [ADDR_W-1:0] araddr_o,
   output logic [7:0]        arlen_o,
   output logic              fire_o
);
   assign fire_o = arvalid_o & arready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arvalid_o <= 1'b0;
         araddr_o  <= '0;
         arlen_o   <= '0;
      end else if (issue_i) begin
         arvalid_o <= 1'b1;
         araddr_o  <= addr_i;
         arlen_o   <= len_i;
      end else if (fire_o) begin
         arvalid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_beat_writer.sv
module dma_beat_writer #(
   parameter int DATA_W = 64,
   parameter int SP_AW  = 10,
   parameter bit SP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              beat_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [1:0]        rresp_i,
   output logic              sp_we_o,
   output logic [SP_AW-1:0]  sp_addr_o,
   output logic [DATA_W-1:0] sp_wdata_o,
   output logic              err_o
);
   import dma_rd_pkg::*;

   logic [SP_AW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         err_o <= 1'b0;
      end else if (clr_i) begin
         idx_q <= '0;
         err_o <= 1'b0;
      end else if (beat_i) begin
         idx_q <= idx_q + SP_AW'(1);
         if (rresp_i != RESP_OKAY) begin
            err_o <= 1'b1;
         end
      end
   end

   generate
      if (SP_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sp_we_o    <= 1'b0;
               sp_addr_o  <= '0;
               sp_wdata_o <= '0;
            end else begin
               sp_we_o <= beat_i;
               if (beat_i) begin
                  sp_addr_o  <= idx_q;
                  sp_wdata_o <= rdata_i;
               end
            end
         end
      end else begin : g_comb
         assign sp_we_o    = beat_i;
         assign sp_addr_o  = idx_q;
         assign sp_wdata_o = rdata_i;
      end
   endgenerate

endmodule

// File: rtl/rd_burst_dma.sv
module rd_burst_dma #(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 64,
   parameter int CNT_W          = 16,
   parameter int SP_AW          = 10,
   parameter int MAX_BEATS      = 256,
   parameter int BOUND_BYTES    = 4096,
   parameter bit SPLIT_AT_BOUND = 1'b1,
   parameter bit SP_REG         = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [CNT_W-1:0]  start_bytes_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              arvalid_o,
   input  logic              arready_i,
   output logic [ADDR_W-1:0] araddr_o,
   output logic [7:0]        arlen_o,
   output logic [2:0]        arsize_o,
   output logic [1:0]        arburst_o,
   input  logic              rvalid_i,
   output logic              rready_o,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [1:0]        rresp_i,
   input  logic              rlast_i,
   output logic              sp_we_o,
   output logic [SP_AW-1:0]  sp_addr_o,
   output logic [DATA_W-1:0] sp_wdata_o
);
   import dma_rd_pkg::*;

   localparam int BUS_BYTES = DATA_W / 8;
   localparam int BB_LG     = $clog2(BUS_BYTES);
   localparam int LEN_W     = $clog2(MAX_BEATS) + 1;
   localparam int BND_LG    = $clog2(BOUND_BYTES);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power of two of at least 8");
      end
      if (MAX_BEATS < 1 || MAX_BEATS > 256) begin : g_bad_max_beats
         $error("MAX_BEATS must lie in 1..256");
      end
      if ((BOUND_BYTES & (BOUND_BYTES - 1)) != 0 || BOUND_BYTES < BUS_BYTES * 2) begin : g_bad_bound
         $error("BOUND_BYTES must be a power of two above the bus width");
      end
      if (CNT_W <= BB_LG || ADDR_W <= BND_LG) begin : g_bad_widths
         $error("CNT_W or ADDR_W too narrow");
      end
      if (SP_AW < 1) begin : g_bad_sp_aw
         $error("SP_AW must be at least 1");
      end
   endgenerate

   dma_state_e        state_q;
   logic [ADDR_W-1:0] cur_addr_q;
   logic [CNT_W-1:0]  rem_beats_q;

   logic              take_start;
   logic              issue;
   logic              ar_fire;
   logic              beat_fire;
   logic [LEN_W-1:0]  plan_beats;
   logic [7:0]        plan_len;

   assign take_start = start_i && (state_q == ST_IDLE);
   assign issue      = (state_q == ST_ISSUE);
   assign rready_o   = (state_q == ST_DATA);
   assign beat_fire  = rvalid_i & rready_o;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = (state_q == ST_FIN);
   assign arsize_o   = 3'(BB_LG);
   assign arburst_o  = BURST_INCR;

   generate
      if (BB_LG > 0) begin : g_lowbits
         logic unused_low;
         assign unused_low = ^start_bytes_i[BB_LG-1:0];
      end
   endgenerate

   dma_burst_plan #(
      .CNT_W          (CNT_W),
      .BUS_BYTES      (BUS_BYTES),
      .MAX_BEATS      (MAX_BEATS),
      .BOUND_BYTES    (BOUND_BYTES),
      .SPLIT_AT_BOUND (SPLIT_AT_BOUND),
      .LEN_W          (LEN_W),
      .BND_LG         (BND_LG)
   ) u_plan (
      .page_off_i  (cur_addr_q[BND_LG-1:0]),
      .rem_beats_i (rem_beats_q),
      .beats_o     (plan_beats),
      .arlen_o     (plan_len)
   );

   dma_ar_chan #(
      .ADDR_W (ADDR_W)
   ) u_ar (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_i   (issue),
      .addr_i    (cur_addr_q),
      .len_i     (plan_len),
      .arready_i (arready_i),
      .arvalid_o (arvalid_o),
      .araddr_o  (araddr_o),
      .arlen_o   (arlen_o),
      .fire_o    (ar_fire)
   );

   dma_beat_writer #(
      .DATA_W (DATA_W),
      .SP_AW  (SP_AW),
      .SP_REG (SP_REG)
   ) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (take_start),
      .beat_i     (beat_fire),
      .rdata_i    (rdata_i),
      .rresp_i    (rresp_i),
      .sp_we_o    (sp_we_o),
      .sp_addr_o  (sp_addr_o),
      .sp_wdata_o (sp_wdata_o),
      .err_o      (err_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_addr_q  <= '0;
         rem_beats_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (take_start) begin
                  cur_addr_q  <= start_addr_i;
                  rem_beats_q <= start_bytes_i >> BB_LG;
                  state_q     <= ((start_bytes_i >> BB_LG) == '0) ? ST_FIN : ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               cur_addr_q  <= cur_addr_q + (ADDR_W'(plan_beats) << BB_LG);
               rem_beats_q <= rem_beats_q - CNT_W'(plan_beats);
               state_q     <= ST_WAIT_AR;
            end
            ST_WAIT_AR: begin
               if (ar_fire) begin
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (beat_fire && rlast_i) begin
                  state_q <= (rem_beats_q == '0) ? ST_FIN : ST_ISSUE;
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rd_burst_dma_chk.sv
module rd_burst_dma_chk #(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 64,
   parameter int SP_AW          = 10,
   parameter int BOUND_BYTES    = 4096,
   parameter bit SPLIT_AT_BOUND = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              arvalid_o,
   input logic              arready_i,
   input logic [ADDR_W-1:0] araddr_o,
   input logic [7:0]        arlen_o,
   input logic [2:0]        arsize_o,
   input logic [1:0]        arburst_o,
   input logic              rvalid_i,
   input logic              rready_o,
   input logic              rlast_i,
   input logic              sp_we_o,
   input logic [SP_AW-1:0]  sp_addr_o
);
   localparam int BUS_BYTES = DATA_W / 8;
   localparam int BND_LG    = $clog2(BOUND_BYTES);

   logic             outst_q;
   logic [SP_AW-1:0] wr_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q  <= 1'b0;
         wr_idx_q <= '0;
      end else begin
         if (arvalid_o && arready_i) begin
            outst_q <= 1'b1;
         end else if (rvalid_i && rready_o && rlast_i) begin
            outst_q <= 1'b0;
         end
         if (start_i && !busy_o) begin
            wr_idx_q <= '0;
         end else if (sp_we_o) begin
            wr_idx_q <= wr_idx_q + SP_AW'(1);
         end
      end
   end

   p_ar_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid_o |-> (arburst_o == 2'b01) && (int'(arsize_o) == $clog2(BUS_BYTES)));

   generate
      if (SPLIT_AT_BOUND) begin : g_cross
         p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
            arvalid_o |-> (int'(araddr_o[BND_LG-1:0]) + (int'(arlen_o) + 1) * BUS_BYTES
                           <= BOUND_BYTES));
      end
   endgenerate

   p_ar_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid_o && !arready_i) |=> arvalid_o && $stable(araddr_o) && $stable(arlen_o));

   p_one_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> rready_o && !arvalid_o);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !arvalid_o && !rready_o);

   p_sp_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we_o |-> (sp_addr_o == wr_idx_q));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !outst_q && !arvalid_o);

   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> !err_o);

endmodule

bind rd_burst_dma rd_burst_dma_chk #(
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W),
   .SP_AW          (SP_AW),
   .BOUND_BYTES    (BOUND_BYTES),
   .SPLIT_AT_BOUND (SPLIT_AT_BOUND)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .arvalid_o (arvalid_o),
   .arready_i (arready_i),
   .araddr_o  (araddr_o),
   .arlen_o   (arlen_o),
   .arsize_o  (arsize_o),
   .arburst_o (arburst_o),
   .rvalid_i  (rvalid_i),
   .rready_o  (rready_o),
   .rlast_i   (rlast_i),
   .sp_we_o   (sp_we_o),
   .sp_addr_o (sp_addr_o)
);

// File: tb/rd_burst_dma_tb_top.sv
module rd_burst_dma_tb_top;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 64;
   localparam int CNT_W  = 16;
   localparam int SP_AW  = 10;
   localparam int BB     = 8;
   localparam int MAXLOG = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] start_addr_i = '0;
   logic [CNT_W-1:0]  start_bytes_i = '0;
   logic              busy_o, done_o, err_o;
   logic              arvalid_o;
   logic              arready_i = 1'b0;
   logic [ADDR_W-1:0] araddr_o;
   logic [7:0]        arlen_o;
   logic [2:0]        arsize_o;
   logic [1:0]        arburst_o;
   logic              rvalid_i = 1'b0;
   logic              rready_o;
   logic [DATA_W-1:0] rdata_i = '0;
   logic [1:0]        rresp_i = 2'b00;
   logic              rlast_i = 1'b0;
   logic              sp_we_o;
   logic [SP_AW-1:0]  sp_addr_o;
   logic [DATA_W-1:0] sp_wdata_o;

   always #2 clk = ~clk;

   rd_burst_dma dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .start_bytes_i(start_bytes_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .arvalid_o(arvalid_o), .arready_i(arready_i), .araddr_o(araddr_o),
      .arlen_o(arlen_o), .arsize_o(arsize_o), .arburst_o(arburst_o),
      .rvalid_i(rvalid_i), .rready_o(rready_o), .rdata_i(rdata_i), .rresp_i(rresp_i),
      .rlast_i(rlast_i), .sp_we_o(sp_we_o), .sp_addr_o(sp_addr_o), .sp_wdata_o(sp_wdata_o)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // responder and observer state
   int          cyc = 0;
   int          log_n = 0;
   logic [31:0] log_addr [MAXLOG];
   logic [7:0]  log_len  [MAXLOG];
   int          bad_fixed = 0;
   int          beats_rx = 0;
   int          rlast_cyc = -1;
   int          done_cnt = 0;
   int          done_cyc = -1;
   logic        done_err = 1'b0;
   logic [63:0] sp_model [1024];
   logic        inj_en = 1'b0;
   logic [31:0] inj_addr = '0;

   logic [31:0] s_addr = '0;
   int          s_left = 0;
   logic        ar_hs_q = 1'b0, r_hs_q = 1'b0, rlast_q = 1'b0;
   logic [31:0] araddr_q;
   logic [7:0]  arlen_q;
   logic [2:0]  arsize_q;
   logic [1:0]  arburst_q;

   // expected burst list
   int          exp_n;
   logic [31:0] exp_addr [MAXLOG];
   logic [7:0]  exp_len  [MAXLOG];

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {a ^ 32'hC3A5_5A3C, a * 32'h0001_0003 + 32'h0000_1357};
   endfunction

   task automatic build_expected(input logic [31:0] addr, input int bytes);
      logic [31:0] a = addr;
      int rem = bytes / BB;
      exp_n = 0;
      while (rem > 0) begin
         int room = (4096 - int'(a % 4096)) / BB;
         int n = rem;
         if (n > 256) n = 256;
         if (n > room) n = room;
         exp_addr[exp_n] = a;
         exp_len[exp_n]  = 8'(n - 1);
         exp_n++;
         a   = a + 32'(n * BB);
         rem = rem - n;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // memory responder and output observer, all on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (ar_hs_q) begin
            if (log_n < MAXLOG) begin
               log_addr[log_n] = araddr_q;
               log_len[log_n]  = arlen_q;
            end
            log_n++;
            if (arsize_q != 3'd3 || arburst_q != 2'b01) bad_fixed++;
            s_addr = araddr_q;
            s_left = int'(arlen_q) + 1;
         end
         if (r_hs_q) begin
            beats_rx++;
            if (rlast_q) rlast_cyc = cyc;
            s_addr = s_addr + 32'(BB);
            s_left--;
         end
         if (sp_we_o) sp_model[sp_addr_o] = sp_wdata_o;
         if (done_o) begin
            done_cnt++;
            done_cyc = cyc;
            done_err = err_o;
         end
         arready_i = arvalid_o ? (($urandom % 4) != 0) : 1'(($urandom % 2));
         if (s_left > 0 && (($urandom % 4) != 0)) begin
            rvalid_i = 1'b1;
            rdata_i  = mem_word(s_addr);
            rlast_i  = (s_left == 1);
            rresp_i  = (inj_en && s_addr == inj_addr) ? 2'b10 : 2'b00;
         end else begin
            rvalid_i = 1'b0;
            rdata_i  = '0;
            rlast_i  = 1'b0;
            rresp_i  = 2'b00;
         end
         ar_hs_q   = arvalid_o && arready_i;
         araddr_q  = araddr_o;
         arlen_q   = arlen_o;
         arsize_q  = arsize_o;
         arburst_q = arburst_o;
         r_hs_q    = rvalid_i && rready_o;
         rlast_q   = rlast_i;
      end
   end

   task automatic run_xfer(input logic [31:0] addr, input int bytes,
                           input bit inject, input logic [31:0] bad_addr,
                           input bit intrude, input string tag);
      int start_done = done_cnt;
      int waited = 0;
      bit ok;
      inj_en   = inject;
      inj_addr = bad_addr;
      log_n    = 0;
      beats_rx = 0;
      bad_fixed = 0;
      rlast_cyc = -1;
      for (int i = 0; i < 1024; i++) sp_model[i] = '0;
      build_expected(addr, bytes);
      @(negedge clk);
      start_i = 1'b1;
      start_addr_i = addr;
      start_bytes_i = CNT_W'(bytes);
      @(negedge clk);
      start_i = 1'b0;
      if (intrude) begin
         repeat (4) @(negedge clk);
         start_i = 1'b1;
         start_addr_i = 32'h0000_8000;
         start_bytes_i = 16'd64;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (done_cnt == start_done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      repeat (3) @(negedge clk);
      check(done_cnt == start_done + 1, "R8", {tag, " done pulse count"},
            done_cnt - start_done, 1);
      // burst list R2 R4 (and R1 when intruded)
      ok = (log_n == exp_n);
      for (int i = 0; i < exp_n && ok; i++)
         ok = (log_addr[i] == exp_addr[i]) && (log_len[i] == exp_len[i]);
      check(ok, intrude ? "R1" : "R4", {tag, " burst list count"}, log_n, exp_n);
      check(bad_fixed == 0, "R2", {tag, " arsize/arburst"}, bad_fixed, 0);
      ok = 1'b1;
      for (int i = 0; i < log_n && i < MAXLOG; i++) begin
         longint first = log_addr[i];
         longint last  = first + (longint'(log_len[i]) + 1) * BB - 1;
         if ((first / 4096) != (last / 4096)) ok = 1'b0;
      end
      check(ok, "R3", {tag, " no 4KB crossing"}, ok, 1);
      check(beats_rx == bytes / BB, "R7", {tag, " beats accepted"}, beats_rx, bytes / BB);
      ok = 1'b1;
      for (int i = 0; i < bytes / BB; i++) begin
         if (ok && sp_model[i] != mem_word(addr + 32'(i * BB))) begin
            ok = 1'b0;
            check(1'b0, "R7", {tag, " scratchpad word"}, longint'(sp_model[i]),
                  longint'(mem_word(addr + 32'(i * BB))));
         end
      end
      if (ok) check(1'b1, "R7", {tag, " scratchpad contents"}, 0, 0);
      if (bytes > 0)
         check(done_cyc == rlast_cyc, "R8", {tag, " done timing vs last beat"},
               done_cyc, rlast_cyc);
      check(done_err == inject, "R9", {tag, " error flag at done"}, done_err, inject);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !err_o && !arvalid_o && !rready_o && !sp_we_o,
            "R11", "reset outputs",
            {busy_o, done_o, err_o, arvalid_o, rready_o, sp_we_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: zero-byte command
      start_i = 1'b1; start_addr_i = 32'h100; start_bytes_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      check(done_o == 1'b1, "R10", "zero-byte done next cycle", done_o, 1);
      @(negedge clk);
      check(!done_o && !busy_o && log_n == 0, "R10", "zero-byte no burst", log_n, 0);

      // R4: full page at 0 splits at the 256-beat ceiling
      run_xfer(32'h0, 4096, 1'b0, 0, 1'b0, "ceiling");
      // R3: crossing a page boundary
      run_xfer(32'h0000_0FF0, 64, 1'b0, 0, 1'b0, "page-cross");
      // single beat
      run_xfer(32'h0000_2008, 8, 1'b0, 0, 1'b0, "one-beat");
      // R9: injected error, then a clean run clears it
      run_xfer(32'h0000_3000, 128, 1'b1, 32'h0000_3040, 1'b0, "err-inject");
      run_xfer(32'h0000_3000, 128, 1'b0, 0, 1'b0, "err-clear");
      // R1: start while busy is ignored
      run_xfer(32'h0000_5F00, 1024, 1'b0, 0, 1'b1, "intrude");

      for (int t = 0; t < 10; t++) begin
         logic [31:0] a;
         int nb;
         if (t % 2 == 0) a = 32'(4096 * (1 + $urandom % 15)) - 32'(8 * ($urandom % 40));
         else            a = ($urandom % 32'h0001_0000) & 32'hFFFF_FFF8;
         nb = 8 * (1 + int'($urandom % 700));
         run_xfer(a, nb, 1'b0, 0, 1'b0, $sformatf("rand%0d", t));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule